// File: doc/BRIEF.md
# Multi-Mode Effective Address Generator

This block turns the operand fields of a decoded memory instruction into the effective address for a multi-cycle or microcoded CPU. A start strobe launches a calculation. The block takes a 3-bit mode code, the base and index register values, a 16-bit signed constant and a 2-bit access-size code. It returns the address with a done strobe.

Two of the modes change the base register: post-increment and pre-decrement. For these, the block also drives a one-cycle write-back enable and the new base value for the register file. Memory-indirect mode makes one extra memory read through a request/response port. The word that comes back becomes the address.

The plain modes finish one cycle after start. The indirect mode finishes one cycle after the memory response. While an indirect read is pending, the block ignores new start strobes.

Top module: `ea_gen`

## Requirements
- R1: While rst_ni is low, and after it is released with no start, done_o, wb_en_o and mem_req_o are 0 and ea_o is 0.
- R2: Mode 0 (absolute): ea_o equals disp_i sign-extended from 16 to 32 bits.
- R3: Mode 1 (register indirect) gives ea_o = base_i. Mode 2 (indexed) gives base_i + index_i. Mode 3 (displacement) gives base_i + sign-extended disp_i.
- R4: Mode 4 (scaled) gives ea_o = sign-extended disp_i + base_i + (index_i << size_i). The size code 0/1/2/3 selects 1/2/4/8 bytes.
- R5: Mode 5 (post-increment) gives ea_o = base_i. In the same cycle as done_o it gives wb_en_o = 1 and wb_data_o = base_i + (1 << size_i).
- R6: Mode 6 (pre-decrement) gives ea_o = wb_data_o = base_i - (1 << size_i), with wb_en_o = 1 in the same cycle as done_o.
- R7: Mode 7 (memory indirect) works in three steps:
  - The cycle after start, mem_req_o = 1 and mem_addr_o = base_i.
  - Both stay unchanged until mem_rvalid_i is sampled high.
  - The next cycle, done_o = 1, ea_o = mem_rdata_i, wb_en_o = 0 and mem_req_o = 0.
- R8: A start_i sampled while mem_req_o is 1 is ignored. This includes the edge that samples mem_rvalid_i. Such a start raises no done_o or wb_en_o and does not change ea_o.
- R9: For modes 0 to 6, done_o is 1 exactly in the cycle after start is sampled. With start low, done_o and wb_en_o are 0. wb_en_o is never 1 for modes 0 to 4 or 7.
- R10: All address arithmetic wraps modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launch a calculation |
| mode_i | input | 3 | Addressing mode code |
| base_i | input | 32 | Base register value |
| index_i | input | 32 | Index register value |
| disp_i | input | 16 | Signed constant / displacement |
| size_i | input | 2 | log2 of access size |
| ea_o | output | 32 | Effective address (held) |
| done_o | output | 1 | Address valid strobe |
| wb_en_o | output | 1 | Base register write-back enable |
| wb_data_o | output | 32 | New base register value |
| mem_req_o | output | 1 | Indirect read request (level) |
| mem_addr_o | output | 32 | Indirect read address |
| mem_rvalid_i | input | 1 | Indirect read response valid |
| mem_rdata_i | input | 32 | Indirect read data |

## Verification
Two pairs of events can land on the same clock edge.

The first pair is done_o and the base write-back in the post-increment and pre-decrement modes. The bench sweeps every mode and size back to back, so the two strobes can be checked together in each cycle. It checks that both rise together, that the address and the write-back value are each correct, and that wb_en_o stays low in every other mode.

The second pair is the indirect read's response and a new start. The bench drives start_i high with another mode in the same cycle as mem_rvalid_i, and also during the wait. It then confirms that ea_o carries the read data, that only one done_o appears, and that no write-back appears.

// File: rtl/ea_pkg.sv
package ea_pkg;
  localparam int unsigned ADDR_W = 32;
  localparam int unsigned DISP_W = 16;

  typedef enum logic [2:0] {
    MODE_ABS     = 3'd0,
    MODE_REG_IND = 3'd1,
    MODE_INDEXED = 3'd2,
    MODE_DISP    = 3'd3,
    MODE_SCALED  = 3'd4,
    MODE_POST_INC = 3'd5,
    MODE_PRE_DEC = 3'd6,
    MODE_MEM_IND = 3'd7
  } ea_mode_e;
endpackage

// File: rtl/ea_calc.sv
module ea_calc
  import ea_pkg::*;
#(
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned DW = DISP_W
) (
  input  logic [2:0]    mode_i,
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] index_i,
  input  logic [DW-1:0] disp_i,
  input  logic [1:0]    size_i,
  output logic [AW-1:0] ea_o,
  output logic [AW-1:0] wb_data_o,
  output logic          wb_en_o,
  output logic          indirect_o
);
  localparam int unsigned EXT_W = AW - DW;

  logic [AW-1:0] disp_sx, step, idx_scaled, base_plus_disp, base_minus_step;

  assign disp_sx         = {{EXT_W{disp_i[DW-1]}}, disp_i};
  assign step            = {{(AW-1){1'b0}}, 1'b1} << size_i;
  assign idx_scaled      = index_i << size_i;
  assign base_plus_disp  = base_i + disp_sx;
  assign base_minus_step = base_i - step;

  always_comb begin
    ea_o       = base_i;
    wb_data_o  = base_i;
    wb_en_o    = 1'b0;
    indirect_o = 1'b0;
    unique case (ea_mode_e'(mode_i))
      MODE_ABS:      ea_o = disp_sx;
      MODE_REG_IND:  ea_o = base_i;
      MODE_INDEXED:  ea_o = base_i + index_i;
      MODE_DISP:     ea_o = base_plus_disp;
      MODE_SCALED:   ea_o = base_plus_disp + idx_scaled;
      MODE_POST_INC: begin
        ea_o      = base_i;
        wb_data_o = base_i + step;
        wb_en_o   = 1'b1;
      end
      MODE_PRE_DEC: begin
        ea_o      = base_minus_step;
        wb_data_o = base_minus_step;
        wb_en_o   = 1'b1;
      end
      MODE_MEM_IND:  indirect_o = 1'b1;
      default:       ea_o = base_i;
    endcase
  end
endmodule

// File: rtl/ea_ind_ctrl.sv
module ea_ind_ctrl #(
  parameter int unsigned AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          launch_i,
  input  logic [AW-1:0] base_i,
  input  logic          rvalid_i,
  output logic          req_o,
  output logic [AW-1:0] addr_o,
  output logic          resp_o
);
  typedef enum logic {ST_IDLE, ST_WAIT} st_e;
  st_e st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      addr_o <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (launch_i) begin
          st_q   <= ST_WAIT;
          addr_o <= base_i;
        end
        ST_WAIT: if (rvalid_i) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign req_o  = (st_q == ST_WAIT);
  assign resp_o = req_o && rvalid_i;
endmodule

// File: rtl/ea_gen.sv
module ea_gen
  import ea_pkg::*;
#(
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned DW = DISP_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [2:0]    mode_i,
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] index_i,
  input  logic [DW-1:0] disp_i,
  input  logic [1:0]    size_i,
  output logic [AW-1:0] ea_o,
  output logic          done_o,
  output logic          wb_en_o,
  output logic [AW-1:0] wb_data_o,
  output logic          mem_req_o,
  output logic [AW-1:0] mem_addr_o,
  input  logic          mem_rvalid_i,
  input  logic [AW-1:0] mem_rdata_i
);
  logic [AW-1:0] calc_ea, calc_wb;
  logic          calc_wb_en, calc_ind, accept, resp;

  ea_calc #(.AW(AW), .DW(DW)) u_calc (
    .mode_i    (mode_i),
    .base_i    (base_i),
    .index_i   (index_i),
    .disp_i    (disp_i),
    .size_i    (size_i),
    .ea_o      (calc_ea),
    .wb_data_o (calc_wb),
    .wb_en_o   (calc_wb_en),
    .indirect_o(calc_ind)
  );

  // starts are dropped while an indirect read is outstanding
  assign accept = start_i && !mem_req_o;

  ea_ind_ctrl #(.AW(AW)) u_ind (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .launch_i(accept && calc_ind),
    .base_i  (base_i),
    .rvalid_i(mem_rvalid_i),
    .req_o   (mem_req_o),
    .addr_o  (mem_addr_o),
    .resp_o  (resp)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ea_o      <= '0;
      done_o    <= 1'b0;
      wb_en_o   <= 1'b0;
      wb_data_o <= '0;
    end else begin
      done_o  <= 1'b0;
      wb_en_o <= 1'b0;
      if (resp) begin
        ea_o   <= mem_rdata_i;
        done_o <= 1'b1;
      end else if (accept && !calc_ind) begin
        ea_o    <= calc_ea;
        done_o  <= 1'b1;
        wb_en_o <= calc_wb_en;
        if (calc_wb_en) wb_data_o <= calc_wb;
      end
    end
  end
endmodule

// File: rtl/ea_gen_chk.sv
module ea_gen_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        start_i,
  input logic [2:0]  mode_i,
  input logic [31:0] base_i,
  input logic [31:0] ea_o,
  input logic        done_o,
  input logic        wb_en_o,
  input logic        mem_req_o,
  input logic [31:0] mem_addr_o,
  input logic        mem_rvalid_i,
  input logic [31:0] mem_rdata_i
);
  AST_WB_WITH_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_en_o |-> done_o); // R5
  AST_PLAIN_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !mem_req_o && mode_i != 3'd7) |=> done_o); // R9
  AST_POST_INC_EA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !mem_req_o && mode_i == 3'd5) |=> (wb_en_o && ea_o == $past(base_i))); // R5
  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_rvalid_i) |=> (mem_req_o && $stable(mem_addr_o))); // R7
  AST_IND_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_rvalid_i) |=> (done_o && !wb_en_o && !mem_req_o && ea_o == $past(mem_rdata_i))); // R7
  AST_BUSY_IGNORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_rvalid_i) |=> !done_o); // R8
  AST_IND_REQ_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !mem_req_o && mode_i == 3'd7) |=> (mem_req_o && mem_addr_o == $past(base_i))); // R7
endmodule

bind ea_gen ea_gen_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .mode_i      (mode_i),
  .base_i      (base_i),
  .ea_o        (ea_o),
  .done_o      (done_o),
  .wb_en_o     (wb_en_o),
  .mem_req_o   (mem_req_o),
  .mem_addr_o  (mem_addr_o),
  .mem_rvalid_i(mem_rvalid_i),
  .mem_rdata_i (mem_rdata_i)
);

// File: tb/tb_ea_gen.sv
module tb_ea_gen;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [2:0]  mode_i = '0;
  logic [31:0] base_i = '0, index_i = '0;
  logic [15:0] disp_i = '0;
  logic [1:0]  size_i = '0;
  logic [31:0] ea_o, wb_data_o, mem_addr_o;
  logic        done_o, wb_en_o, mem_req_o;
  logic        mem_rvalid_i = 1'b0;
  logic [31:0] mem_rdata_i = '0;

  int n_chk = 0, n_fail = 0;

  ea_gen dut (.*);

  always #10 clk_i = ~clk_i;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] sx(input logic [15:0] d);
    return {{16{d[15]}}, d};
  endfunction

  // drive an op with start high; check one cycle later (start left high for back-to-back)
  task automatic plain_op(input logic [2:0] m, input logic [31:0] b, input logic [31:0] x,
                          input logic [15:0] d, input logic [1:0] s);
    logic [31:0] exp_ea, exp_wb, step;
    bit exp_wben;
    string tag;
    step = 32'd1 << s;
    exp_wb = 'x; exp_wben = 0;
    case (m)
      3'd0: begin exp_ea = sx(d); tag = "R2"; end
      3'd1: begin exp_ea = b; tag = "R3"; end
      3'd2: begin exp_ea = b + x; tag = "R3"; end
      3'd3: begin exp_ea = b + sx(d); tag = "R3"; end
      3'd4: begin exp_ea = sx(d) + b + (x << s); tag = "R4"; end
      3'd5: begin exp_ea = b; exp_wb = b + step; exp_wben = 1; tag = "R5"; end
      default: begin exp_ea = b - step; exp_wb = b - step; exp_wben = 1; tag = "R6"; end
    endcase
    mode_i = m; base_i = b; index_i = x; disp_i = d; size_i = s; start_i = 1'b1;
    @(negedge clk_i);
    chk(ea_o == exp_ea, tag, ea_o, exp_ea);
    chk(done_o == 1'b1, "R9 done", {31'd0, done_o}, 32'd1);
    chk(wb_en_o == exp_wben, "R9 wb_en", {31'd0, wb_en_o}, {31'd0, exp_wben});
    if (exp_wben) chk(wb_data_o == exp_wb, tag, wb_data_o, exp_wb);
  endtask

  initial begin
    #(200000 * 20);
    n_fail++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] bases [6] = '{32'h0, 32'h1, 32'h7FFF_FFFF, 32'hFFFF_FFFC, 32'h8000_0000, 32'h1234_5678};
    logic [31:0] idxs [4]  = '{32'h0, 32'h3, 32'hFFFF_FFFF, 32'h4000_0001};
    logic [15:0] disps [5] = '{16'h0, 16'h1, 16'h7FFF, 16'h8000, 16'hFFFF};
    logic [31:0] held;

    repeat (3) @(negedge clk_i);
    chk(!done_o && !wb_en_o && !mem_req_o && ea_o == 0, "R1 in reset", ea_o, 32'd0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    chk(!done_o && !wb_en_o && !mem_req_o && ea_o == 0, "R1 after reset", ea_o, 32'd0);

    // exhaustive sweep of plain modes, back to back
    for (int m = 0; m < 7; m++)
      for (int s = 0; s < 4; s++)
        for (int b = 0; b < 6; b++)
          for (int x = 0; x < 4; x++)
            for (int d = 0; d < 5; d++)
              plain_op(3'(m), bases[b], idxs[x], disps[d], 2'(s));
    start_i = 1'b0;
    @(negedge clk_i);
    chk(!done_o && !wb_en_o, "R9 idle after sweep", {31'd0, done_o}, 32'd0);

    // R10 wrap cases
    plain_op(3'd3, 32'hFFFF_FFFF, 32'd0, 16'h0002, 2'd0);
    chk(ea_o == 32'h1, "R10 disp wrap", ea_o, 32'h1);
    plain_op(3'd6, 32'h0, 32'd0, 16'h0, 2'd3);
    chk(wb_data_o == 32'hFFFF_FFF8, "R10 predec wrap", wb_data_o, 32'hFFFF_FFF8);
    plain_op(3'd5, 32'hFFFF_FFFE, 32'd0, 16'h0, 2'd2);
    chk(wb_data_o == 32'h2, "R10 postinc wrap", wb_data_o, 32'h2);
    start_i = 1'b0;
    @(negedge clk_i);

    // memory-indirect with several latencies, start poked during the wait and at the response
    for (int lat = 0; lat < 5; lat++) begin
      logic [31:0] b, rd;
      b  = 32'h1000_0000 + 32'(lat * 4);
      rd = 32'hA5A5_0000 ^ 32'(lat * 32'h111);
      held = ea_o;
      mode_i = 3'd7; base_i = b; start_i = 1'b1;
      @(negedge clk_i);
      start_i = 1'b0;
      chk(mem_req_o && mem_addr_o == b, "R7 req addr", mem_addr_o, b);
      chk(!done_o, "R7 no early done", {31'd0, done_o}, 32'd0);
      for (int w = 0; w < lat; w++) begin
        mode_i = 3'd0; disp_i = 16'h1234; start_i = (w == 0);
        base_i = 32'hDEAD_0000;
        @(negedge clk_i);
        start_i = 1'b0;
        chk(mem_req_o && mem_addr_o == b, "R7 req held", mem_addr_o, b);
        chk(!done_o && !wb_en_o && ea_o == held, "R8 start ignored", ea_o, held);
      end
      mem_rvalid_i = 1'b1; mem_rdata_i = rd;
      start_i = 1'b1; mode_i = 3'd5; base_i = 32'h55;
      @(negedge clk_i);
      mem_rvalid_i = 1'b0; start_i = 1'b0;
      chk(done_o && ea_o == rd, "R7 result", ea_o, rd);
      chk(!wb_en_o && !mem_req_o, "R8 start at response ignored", {31'd0, wb_en_o}, 32'd0);
      @(negedge clk_i);
      chk(!done_o && ea_o == rd, "R8 single done", {31'd0, done_o}, 32'd0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule